// File: doc/BRIEF.md
# Core Mode and Link Controller

This block sets the runtime mode of every core in a small multi-core cluster. Core 0 is the primary core and always runs as a full CPU. The other cores start out inactive. The primary core issues commands to open a linked section or a threaded section, or to close the section that is open. An open command carries a core count that includes the primary core. The controller picks the secondary cores with enough capability, waits until every affected core is idle, and then switches their modes at the same time. Each taking part core gets an identifier. The primary core is stalled while the change is pending.

Each core has a capability level, fixed by a parameter, that caps the mode it may take. In linked (lockstep SIMD) operation a linked core does not fetch instructions. Its control word is replaced by the decoded control word of the primary core. A conditional branch or register-indirect jump that the primary core decodes during a linked section is reported as a fault.

Top module: `core_mode_ctrl`

## Requirements
- R1: After reset, core 0 is in mode 3 (full CPU) and every other core is in mode 0 (inactive). All identifiers are 0, and `stall_o`, `err_o` and `done_o` are low. Core 0 stays in mode 3 at all times. Mode codes: 0 inactive, 1 linked, 2 autonomous thread, 3 full CPU.
- R2: Op code 1 with count c opens a linked section. Secondary cores with capability of at least 1 are taken in ascending index order until c-1 are chosen. Each chosen core goes to mode 1 and gets identifier 1, 2, and so on in that order. The primary core keeps identifier 0.
- R3: Op code 2 with count c opens a threaded section. It uses the same selection rule, but only cores with capability of at least 2 qualify, and chosen cores go to mode 2.
- R4: Op code 3 closes the open section. Every secondary core returns to mode 0 with identifier 0. This op is accepted even when no section is open.
- R5: An open request is refused in any of these cases: count 0, count minus 1 larger than the number of qualifying secondaries, or a section already open. A refusal raises `err_o` for exactly one cycle after the command edge. No mode or identifier changes, and `stall_o` stays low.
- R6: An accepted command raises `stall_o` from the next cycle. The change is applied at the first clock edge at which every affected core reports idle. `done_o` pulses in the cycle after that edge, and `stall_o` drops then. Modes do not change while an affected core is busy.
- R7: A command presented while `stall_o` is high is ignored. It causes no error and no mode change.
- R8: A core in mode 1 drives on `ctrl_o` the control word of core 0. Every other core drives its own word.
- R9: `fetch_en_o` is high for a core exactly when its mode is 2 or 3.
- R10: `fault_o` is high, in the same cycle, when `prim_branch_i` is high while a linked section is open.
- R11: No core's mode ever exceeds its capability level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe from the primary core |
| cmd_op_i | input | 2 | Op: 1 link, 2 thread, 3 close |
| cmd_cnt_i | input | CNTW | Requested core count including the primary |
| core_idle_i | input | NC | Per-core idle indication |
| own_ctrl_i | input | NC*CW | Per-core decoded control words |
| prim_branch_i | input | 1 | Primary decoded a conditional branch or indirect jump |
| mode_o | output | 2*NC | Per-core mode |
| core_id_o | output | NC*IDW | Per-core identifier |
| ctrl_o | output | NC*CW | Control word each core executes |
| fetch_en_o | output | NC | Per-core instruction fetch enable |
| stall_o | output | 1 | Primary stall while a change is pending |
| err_o | output | 1 | Request refused |
| done_o | output | 1 | Mode change applied |
| fault_o | output | 1 | Control-flow fault during a linked section |

## Verification
The hardest situation to reach is a pending change that is held back by a busy core while a second command arrives. The bench drives the idle inputs low only for the affected cores, and for a random number of cycles. During that wait it injects a close command. Then it checks that modes stay frozen and that no error rises. Random commands run against a bench model of selection and section state. This walks the refusal boundaries (count 0, one core too many, open-while-open) from many starting states.

// File: rtl/core_mode_pkg.sv
package core_mode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_LINK   = 2'd1,
    MODE_THREAD = 2'd2,
    MODE_FULL   = 2'd3
  } core_mode_e;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_LINK   = 2'd1,
    OP_THREAD = 2'd2,
    OP_EXIT   = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/core_mode_select.sv
module core_mode_select #(
  parameter int unsigned NC = 4,
  parameter int unsigned CNTW = 3,
  parameter int unsigned IDW = 2,
  parameter logic [2*NC-1:0] CORE_CAP = '1
) (
  input  logic [1:0]              min_cap_i,
  input  logic [CNTW-1:0]         req_cnt_i,
  output logic [NC-1:0]           sel_mask_o,
  output logic [(NC-1)*IDW-1:0]   sel_ids_o,
  output logic                    fits_o
);
  always_comb begin
    int taken;
    int avail;
    taken = 0;
    avail = 0;
    sel_mask_o = '0;
    sel_ids_o = '0;
    for (int i = 1; i < int'(NC); i++) begin
      if (CORE_CAP[2*i +: 2] >= min_cap_i) begin
        avail++;
        if (taken + 1 < int'(req_cnt_i)) begin
          sel_mask_o[i] = 1'b1;
          sel_ids_o[(i-1)*IDW +: IDW] = IDW'(taken + 1);
          taken++;
        end
      end
    end
    fits_o = (req_cnt_i != '0) && (int'(req_cnt_i) <= avail + 1);
  end
endmodule

// File: rtl/core_mode_route.sv
module core_mode_route
  import core_mode_pkg::*;
#(
  parameter int unsigned NC = 4,
  parameter int unsigned CW = 8
) (
  input  logic [2*NC-1:0]  mode_i,
  input  logic [NC*CW-1:0] own_ctrl_i,
  output logic [NC*CW-1:0] ctrl_o,
  output logic [NC-1:0]    fetch_en_o
);
  for (genvar g = 0; g < NC; g++) begin : g_core
    logic [1:0] m;
    assign m = mode_i[2*g +: 2];
    // linked cores follow the primary's decoded word
    assign ctrl_o[g*CW +: CW] = (m == MODE_LINK) ? own_ctrl_i[CW-1:0]
                                                 : own_ctrl_i[g*CW +: CW];
    assign fetch_en_o[g] = m[1];
  end
endmodule

// File: rtl/core_mode_ctrl.sv
module core_mode_ctrl
  import core_mode_pkg::*;
#(
  parameter int unsigned NC = 4,
  parameter int unsigned CW = 8,
  parameter logic [2*NC-1:0] CORE_CAP = 8'b01_01_10_11,
  localparam int unsigned IDW = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned CNTW = $clog2(NC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [CNTW-1:0]    cmd_cnt_i,
  input  logic [NC-1:0]      core_idle_i,
  input  logic [NC*CW-1:0]   own_ctrl_i,
  input  logic               prim_branch_i,
  output logic [2*NC-1:0]    mode_o,
  output logic [NC*IDW-1:0]  core_id_o,
  output logic [NC*CW-1:0]   ctrl_o,
  output logic [NC-1:0]      fetch_en_o,
  output logic               stall_o,
  output logic               err_o,
  output logic               done_o,
  output logic               fault_o
);
  logic [2*NC-1:0]         mode_q;
  logic [NC*IDW-1:0]       id_q;
  logic                    pend_q, session_q, linked_q, err_q, done_q;
  cmd_op_e                 pend_op_q;
  logic [NC-1:0]           pend_mask_q;
  logic [(NC-1)*IDW-1:0]   pend_ids_q;

  logic [NC-1:0]           sel_mask, active_sec;
  logic [(NC-1)*IDW-1:0]   sel_ids;
  logic                    fits, is_open, accept, refuse, go;

  core_mode_select #(.NC(NC), .CNTW(CNTW), .IDW(IDW), .CORE_CAP(CORE_CAP)) u_sel (
    .min_cap_i  ((cmd_op_i == OP_THREAD) ? 2'd2 : 2'd1),
    .req_cnt_i  (cmd_cnt_i),
    .sel_mask_o (sel_mask),
    .sel_ids_o  (sel_ids),
    .fits_o     (fits)
  );

  core_mode_route #(.NC(NC), .CW(CW)) u_route (
    .mode_i     (mode_q),
    .own_ctrl_i (own_ctrl_i),
    .ctrl_o     (ctrl_o),
    .fetch_en_o (fetch_en_o)
  );

  always_comb begin
    active_sec = '0;
    for (int i = 1; i < int'(NC); i++) active_sec[i] = (mode_q[2*i +: 2] != MODE_OFF);
  end

  assign is_open = (cmd_op_i == OP_LINK) || (cmd_op_i == OP_THREAD);
  assign accept  = cmd_valid_i && !pend_q && (cmd_op_i != OP_NOP);
  assign refuse  = accept && is_open && (session_q || !fits);
  assign go      = pend_q && ((pend_mask_q & ~core_idle_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NC); i++)
        mode_q[2*i +: 2] <= (i == 0) ? MODE_FULL : MODE_OFF;
      id_q        <= '0;
      pend_q      <= 1'b0;
      session_q   <= 1'b0;
      linked_q    <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      pend_op_q   <= OP_NOP;
      pend_mask_q <= '0;
      pend_ids_q  <= '0;
    end else begin
      err_q  <= refuse;
      done_q <= go;
      if (go) begin
        pend_q    <= 1'b0;
        session_q <= (pend_op_q != OP_EXIT);
        linked_q  <= (pend_op_q == OP_LINK);
        for (int i = 1; i < int'(NC); i++) begin
          if (pend_op_q == OP_EXIT) begin
            mode_q[2*i +: 2]   <= MODE_OFF;
            id_q[i*IDW +: IDW] <= '0;
          end else if (pend_mask_q[i]) begin
            mode_q[2*i +: 2]   <= (pend_op_q == OP_LINK) ? MODE_LINK : MODE_THREAD;
            id_q[i*IDW +: IDW] <= pend_ids_q[(i-1)*IDW +: IDW];
          end
        end
      end else if (accept && !refuse) begin
        pend_q      <= 1'b1;
        pend_op_q   <= cmd_op_e'(cmd_op_i);
        pend_mask_q <= (cmd_op_i == OP_EXIT) ? active_sec : sel_mask;
        pend_ids_q  <= sel_ids;
      end
    end
  end

  assign mode_o    = mode_q;
  assign core_id_o = id_q;
  assign stall_o   = pend_q;
  assign err_o     = err_q;
  assign done_o    = done_q;
  assign fault_o   = linked_q && prim_branch_i;

  // R1
  primary_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[1:0] == MODE_FULL);

  for (genvar g = 1; g < NC; g++) begin : g_cap
    // R11
    mode_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q[2*g +: 2] <= CORE_CAP[2*g +: 2]);
  end

  // R5
  refuse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(mode_q) && !stall_o));

  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && ((pend_mask_q & ~core_idle_i) != '0)) |=> $stable(mode_q));

  // R6
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !stall_o);

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !err_o);
endmodule

// File: tb/tb_core_mode_ctrl.sv
module tb_core_mode_ctrl;
  localparam int CLK_P = 10;
  localparam int NC = 4;
  localparam int CW = 8;
  localparam int IDW = 2;
  localparam int CNTW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [CNTW-1:0] cmd_cnt = '0;
  logic [NC-1:0] core_idle = '1;
  logic [NC*CW-1:0] own_ctrl = '0;
  logic prim_branch = 1'b0;
  logic [2*NC-1:0] mode;
  logic [NC*IDW-1:0] core_id;
  logic [NC*CW-1:0] ctrl;
  logic [NC-1:0] fetch_en;
  logic stall, err, done, fault;

  int checks = 0;
  int fails = 0;
  int cap [NC] = '{3, 2, 1, 1};
  int cur_mode [NC];
  int cur_id [NC];
  int nxt_mode [NC];
  int nxt_id [NC];
  bit aff [NC];
  bit session = 0;
  bit linked = 0;
  bit exp_ok;

  always #(CLK_P/2) clk = ~clk;

  core_mode_ctrl #(.NC(NC), .CW(CW), .CORE_CAP(8'b01_01_10_11)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_cnt_i(cmd_cnt), .core_idle_i(core_idle), .own_ctrl_i(own_ctrl),
    .prim_branch_i(prim_branch), .mode_o(mode), .core_id_o(core_id),
    .ctrl_o(ctrl), .fetch_en_o(fetch_en), .stall_o(stall), .err_o(err),
    .done_o(done), .fault_o(fault)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input bit use_next);
    for (int i = 0; i < NC; i++) begin
      chk(int'(mode[2*i +: 2]), use_next ? nxt_mode[i] : cur_mode[i], tag);
      chk(int'(core_id[i*IDW +: IDW]), use_next ? nxt_id[i] : cur_id[i], tag);
    end
  endtask

  // bench model of selection, from R2..R5
  task automatic predict(input int op, input int cnt);
    int need, taken, avail, mc;
    mc = (op == 2) ? 2 : 1;
    need = cnt - 1;
    taken = 0;
    avail = 0;
    for (int i = 0; i < NC; i++) begin
      nxt_mode[i] = cur_mode[i];
      nxt_id[i] = cur_id[i];
      aff[i] = 0;
    end
    if (op == 3) begin
      exp_ok = 1;
      for (int i = 1; i < NC; i++) begin
        aff[i] = (cur_mode[i] != 0);
        nxt_mode[i] = 0;
        nxt_id[i] = 0;
      end
      return;
    end
    for (int i = 1; i < NC; i++) if (cap[i] >= mc) avail++;
    exp_ok = !session && cnt >= 1 && need <= avail;
    if (!exp_ok) return;
    for (int i = 1; i < NC; i++) begin
      if (cap[i] >= mc && taken < need) begin
        taken++;
        aff[i] = 1;
        nxt_mode[i] = (op == 1) ? 1 : 2;
        nxt_id[i] = taken;
      end
    end
  endtask

  task automatic do_cmd(input int op, input int cnt, input int busy, input bit inject);
    int w;
    bit any_aff;
    predict(op, cnt);
    any_aff = 0;
    for (int i = 0; i < NC; i++) any_aff |= aff[i];
    w = (exp_ok && any_aff) ? busy : 0;
    @(negedge clk);
    for (int i = 0; i < NC; i++) core_idle[i] = (w > 0) ? !aff[i] : 1'b1;
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_cnt = CNTW'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (!exp_ok) begin
      chk(int'(err), 1, "R5 err pulse");
      chk(int'(stall), 0, "R5 no stall");
      chk_state("R5 state kept", 0);
      @(negedge clk);
      chk(int'(err), 0, "R5 err one cycle");
      chk_state("R5 state kept later", 0);
      return;
    end
    chk(int'(err), 0, "R6 no err on accept");
    chk(int'(stall), 1, "R6 stall raised");
    if (inject && w > 0) begin
      cmd_valid = 1'b1;
      cmd_op = 2'd3;
      cmd_cnt = '0;
    end
    for (int b = 0; b < w; b++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      chk_state("R6 frozen while busy", 0);
      chk(int'(stall), 1, "R6 stall held");
      chk(int'(err), 0, "R7 no err while stalled");
    end
    cmd_valid = 1'b0;
    core_idle = '1;
    @(negedge clk);
    chk(int'(done), 1, "R6 done pulse");
    chk(int'(stall), 0, "R6 stall released");
    chk_state(op == 3 ? "R4 close" : (op == 1 ? "R2 link" : "R3 thread"), 1);
    for (int i = 0; i < NC; i++) begin
      cur_mode[i] = nxt_mode[i];
      cur_id[i] = nxt_id[i];
    end
    session = (op != 3);
    linked = (op == 1);
  endtask

  task automatic chk_route();
    @(negedge clk);
    own_ctrl = {$urandom(), $urandom()};
    prim_branch = 1'($urandom_range(0, 1));
    #1;
    for (int i = 0; i < NC; i++) begin
      chk(int'(ctrl[i*CW +: CW]),
          int'((cur_mode[i] == 1) ? own_ctrl[CW-1:0] : own_ctrl[i*CW +: CW]), "R8 ctrl route");
      chk(int'(fetch_en[i]), int'(cur_mode[i] >= 2), "R9 fetch enable");
      checks++;
      if (int'(mode[2*i +: 2]) > cap[i]) begin
        fails++;
        $display("FAIL R11 core %0d: actual mode %0d expected <= %0d", i, mode[2*i +: 2], cap[i]);
      end
    end
    chk(int'(fault), int'(linked && prim_branch), "R10 fault");
    prim_branch = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    cur_mode = '{3, 0, 0, 0};
    cur_id = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    chk_state("R1 reset state", 0);
    chk(int'(stall), 0, "R1 stall");
    chk(int'(err), 0, "R1 err");
    chk(int'(done), 0, "R1 done");
    rst_n = 1'b1;
    @(negedge clk);
    chk_route();

    do_cmd(1, 4, 0, 0);   // R2 all three secondaries linked
    chk_route();
    do_cmd(2, 2, 0, 0);   // R5 open while open
    do_cmd(3, 0, 2, 1);   // R4 with R7 injection
    chk_route();
    do_cmd(1, 0, 0, 0);   // R5 count 0
    do_cmd(2, 3, 0, 0);   // R5 one too many threaded
    do_cmd(2, 2, 3, 1);   // R3 core 1 threads, R7 injection
    chk_route();
    do_cmd(3, 0, 0, 0);
    do_cmd(1, 5, 0, 0);   // R5 one too many linked
    do_cmd(1, 2, 1, 0);   // R2 only core 1 linked
    chk_route();
    do_cmd(3, 0, 0, 0);
    do_cmd(3, 0, 2, 0);   // R4 close with nothing open
    do_cmd(1, 1, 0, 0);   // R2 primary alone
    chk_route();
    do_cmd(3, 0, 0, 0);

    for (int k = 0; k < 80; k++) begin
      do_cmd($urandom_range(1, 3), $urandom_range(0, 5), $urandom_range(0, 3),
             1'($urandom_range(0, 1)));
      chk_route();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule